// File: doc/BRIEF.md
# Two-wire slave for synthesizer programming

This block lets a host processor set up a frequency synthesizer over a two-wire serial bus in which the host drives the clock. It runs on a fast system clock and oversamples the bus clock (SCL) and data (SDA) lines. From these samples it finds the start and stop conditions. It shifts in bytes, most significant bit first, on each rising SCL. It acknowledges by pulling SDA low during the ninth clock of a byte.

The first byte after a start holds the 7-bit device address and a direction bit in its least significant bit. The block only responds if the address matches. A write telegram contains no register address. Data bytes come in pairs, and the top bit of the first byte of each pair picks the destination. A 0 selects the 15-bit divider word and a 1 selects the 15-bit control word. The other 7 bits of that first byte become the upper part of the word, and the second byte becomes the lower part. A read returns one status byte that carries the synthesizer's lock flag.

SDA is open-drain. The block only ever pulls the line low or releases it. `sda_oe_o` high means the line is pulled low.

Top module: `synth_i2c_ctrl`

## Requirements
- R1: After reset, `sda_oe_o` is 0 and both `div_word_o` and `ctrl_word_o` are 0.
- R2: An address byte whose upper 7 bits equal `DEV_ADDR` is acknowledged: `sda_oe_o` is 1 while SCL is low before and during the ninth clock.
- R3: An address byte that does not match gets no acknowledge. Until the next start, the block leaves SDA alone and ignores data bytes, so neither word changes.
- R4: In a write, a first data byte with bit 7 = 0 followed by a second byte B2 loads `div_word_o` with {first[6:0], B2}. The load happens on the eighth rising SCL of B2, and every data byte is acknowledged.
- R5: A first data byte with bit 7 = 1 followed by B2 loads `ctrl_word_o` with {first[6:0], B2} in the same way.
- R6: The third data byte of a telegram starts a new pair, and its bit 7 again selects the destination word.
- R7: A pair that is cut off by a stop after only one byte is discarded. The next telegram begins a fresh pair.
- R8: A read (direction bit = 1) returns one status byte, MSB first, which is {lock_i, 7'b0}, with lock_i sampled at the end of the address acknowledge. Neither word changes during a read.
- R9: A start that arrives in the middle of a telegram (repeated start) drops any half-received pair and makes the next byte an address byte again.
- R10: `sda_oe_o` changes only while SCL is low. It is released after the acknowledge clock of a write byte, and after the eighth bit of the status byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| lock_i | input | 1 | Synthesizer lock flag reported on reads |
| sda_oe_o | output | 1 | 1 = pull SDA low, 0 = release |
| div_word_o | output | 15 | Divider ratio word |
| ctrl_word_o | output | 15 | Control word (port and test bits) |

## Verification
The checker assumes that the host changes SDA only while SCL is low, except when it signals a start or a stop. It also assumes that each SCL phase lasts well beyond the synchronizer delay, and that the host never issues a stop while the slave is holding SDA low. Under these conditions, a change of `sda_oe_o` can only happen while SCL is low. The bench host keeps every SCL phase at 10 or more system clocks and changes data in the middle of the low phase. It emits stops only after an acknowledge has been released or after a read has been not-acknowledged.

// File: rtl/synth_i2c_pkg.sv
package synth_i2c_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W - 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_RX,
        PH_ACK,
        PH_TX
    } phase_t;

    typedef struct packed {
        phase_t             phase;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  sh;
        logic               is_addr;
        logic               rd;
        logic               oe;
        logic               stb;
    } eng_st_t;

    typedef struct packed {
        logic               pend;
        logic               ptype;
        logic [BYTE_W-2:0]  pbits;
        logic [WORD_W-1:0]  div;
        logic [WORD_W-1:0]  ctrl;
    } dec_st_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [STAGES-1:0] scl_ch;
        logic [STAGES-1:0] sda_ch;
        logic              scl_p;
        logic              sda_p;
    } sync_st_t;

    sync_st_t sq, sd;
    logic scl_s, sda_s;

    assign scl_s = sq.scl_ch[STAGES-1];
    assign sda_s = sq.sda_ch[STAGES-1];

    always_comb begin
        sd = sq;
        for (int i = STAGES - 1; i > 0; i--) begin
            sd.scl_ch[i] = sq.scl_ch[i-1];
            sd.sda_ch[i] = sq.sda_ch[i-1];
        end
        sd.scl_ch[0] = scl_i;
        sd.sda_ch[0] = sda_i;
        sd.scl_p     = scl_s;
        sd.sda_p     = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq <= '1;
        else        sq <= sd;
    end

    assign sda_lvl   = sda_s;
    assign scl_rise  = scl_s & ~sq.scl_p;
    assign scl_fall  = ~scl_s & sq.scl_p;
    assign start_det = scl_s & sq.scl_p & sq.sda_p & ~sda_s;
    assign stop_det  = scl_s & sq.scl_p & ~sq.sda_p & sda_s;
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
    import synth_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h61
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              lock_i,
    output logic              sda_oe,
    output logic              byte_stb,
    output logic [BYTE_W-1:0] byte_data,
    output logic              rd_mode,
    output logic              eng_idle
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

    eng_st_t q, d;
    logic [BYTE_W-1:0] nsh;

    always_comb begin
        d     = q;
        d.stb = 1'b0;
        nsh   = {q.sh[BYTE_W-2:0], sda_lvl};
        if (start_det) begin
            d.phase   = PH_RX;
            d.cnt     = '0;
            d.is_addr = 1'b1;
            d.rd      = 1'b0;
            d.oe      = 1'b0;
        end else if (stop_det) begin
            d.phase = PH_IDLE;
            d.rd    = 1'b0;
            d.oe    = 1'b0;
        end else begin
            case (q.phase)
                PH_RX: begin
                    if (scl_rise && q.cnt < CNT_FULL) begin
                        d.sh  = nsh;
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == CNT_LAST) begin
                            if (q.is_addr) begin
                                if (nsh[BYTE_W-1:1] == DEV_ADDR) d.rd = nsh[0];
                                else                             d.phase = PH_IDLE;
                            end else begin
                                d.stb = 1'b1;
                            end
                        end
                    end else if (scl_fall && q.cnt == CNT_FULL) begin
                        d.oe    = 1'b1;
                        d.phase = PH_ACK;
                        d.cnt   = '0;
                    end
                end
                PH_ACK: begin
                    if (scl_fall) begin
                        d.cnt     = '0;
                        d.is_addr = 1'b0;
                        if (q.rd) begin
                            d.phase = PH_TX;
                            d.sh    = {lock_i, {(BYTE_W-1){1'b0}}};
                            d.oe    = ~lock_i;
                        end else begin
                            d.phase = PH_RX;
                            d.oe    = 1'b0;
                        end
                    end
                end
                PH_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == CNT_LAST) begin
                            d.phase = PH_IDLE;
                            d.oe    = 1'b0;
                            d.rd    = 1'b0;
                        end else begin
                            d.sh  = {q.sh[BYTE_W-2:0], 1'b0};
                            d.oe  = ~q.sh[BYTE_W-2];
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe    = q.oe;
    assign byte_stb  = q.stb;
    assign byte_data = q.sh;
    assign rd_mode   = q.rd;
    assign eng_idle  = (q.phase == PH_IDLE);
endmodule

// File: rtl/i2c_word_decode.sv
module i2c_word_decode
    import synth_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tel_rst,
    input  logic              byte_stb,
    input  logic [BYTE_W-1:0] byte_data,
    output logic [WORD_W-1:0] div_word,
    output logic [WORD_W-1:0] ctrl_word
);
    dec_st_t q, d;

    always_comb begin
        d = q;
        if (tel_rst) begin
            d.pend = 1'b0;
        end else if (byte_stb) begin
            if (!q.pend) begin
                d.pend  = 1'b1;
                d.ptype = byte_data[BYTE_W-1];
                d.pbits = byte_data[BYTE_W-2:0];
            end else begin
                d.pend = 1'b0;
                if (q.ptype) d.ctrl = {q.pbits, byte_data};
                else         d.div  = {q.pbits, byte_data};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign div_word  = q.div;
    assign ctrl_word = q.ctrl;
endmodule

// File: rtl/synth_i2c_ctrl.sv
module synth_i2c_ctrl
    import synth_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h61,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              lock_i,
    output logic              sda_oe_o,
    output logic [WORD_W-1:0] div_word_o,
    output logic [WORD_W-1:0] ctrl_word_o
);
    logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic byte_stb, rd_mode, eng_idle;
    logic [BYTE_W-1:0] byte_data;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_bit_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .lock_i    (lock_i),
        .sda_oe    (sda_oe_o),
        .byte_stb  (byte_stb),
        .byte_data (byte_data),
        .rd_mode   (rd_mode),
        .eng_idle  (eng_idle)
    );

    i2c_word_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .tel_rst   (start_det | stop_det),
        .byte_stb  (byte_stb),
        .byte_data (byte_data),
        .div_word  (div_word_o),
        .ctrl_word (ctrl_word_o)
    );
endmodule

// File: rtl/synth_i2c_ctrl_chk.sv
module synth_i2c_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_i,
    input logic        sda_oe_o,
    input logic [14:0] div_word_o,
    input logic [14:0] ctrl_word_o,
    input logic        byte_stb,
    input logic        rd_mode,
    input logic        eng_idle
);
    a_r1_oe_known: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(sda_oe_o));

    a_r10_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_i);

    a_r3_idle_releases: assert property (@(posedge clk) disable iff (!rst_n)
        eng_idle |-> !sda_oe_o);

    a_r4_div_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_word_o) |-> $past(byte_stb));

    a_r5_ctrl_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_word_o) |-> $past(byte_stb));

    a_r6_one_word_per_pair: assert property (@(posedge clk) disable iff (!rst_n)
        !(!$stable(div_word_o) && !$stable(ctrl_word_o)));

    a_r8_read_keeps_words: assert property (@(posedge clk) disable iff (!rst_n)
        rd_mode |-> ($stable(div_word_o) && $stable(ctrl_word_o)));
endmodule

bind synth_i2c_ctrl synth_i2c_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_i),
    .sda_oe_o    (sda_oe_o),
    .div_word_o  (div_word_o),
    .ctrl_word_o (ctrl_word_o),
    .byte_stb    (byte_stb),
    .rd_mode     (rd_mode),
    .eng_idle    (eng_idle)
);

// File: tb/tb_synth_i2c_ctrl.sv
module tb_synth_i2c_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic lock = 1'b0;
    logic sda_oe;
    logic [14:0] div_w, ctrl_w;
    logic sda_line;

    assign sda_line = sda_m & ~sda_oe;
    always #2 clk = ~clk;

    synth_i2c_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .lock_i      (lock),
        .sda_oe_o    (sda_oe),
        .div_word_o  (div_w),
        .ctrl_word_o (ctrl_w)
    );

    int total = 0;
    int bad = 0;
    string cur = "R1";
    bit cmp_en = 1'b0;
    logic [14:0] exp_div = '0;
    logic [14:0] exp_ctrl = '0;
    logic [7:0] pend_q[$];
    bit addressed = 1'b0;

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // reference model compared every clock while SCL is low
    always @(posedge clk) begin
        #1;
        if (cmp_en && !scl_m) begin
            chk(cur, "div_word", {1'b0, div_w}, {1'b0, exp_div});
            chk(cur, "ctrl_word", {1'b0, ctrl_w}, {1'b0, exp_ctrl});
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_start();
        pend_q.delete();
        addressed = 1'b0;
    endtask

    task automatic model_byte(logic [7:0] b, bit is_addr);
        if (is_addr) begin
            addressed = (b[7:1] == 7'h61) && !b[0];
        end else if (addressed) begin
            pend_q.push_back(b);
            if (pend_q.size() == 2) begin
                if (pend_q[0][7]) exp_ctrl = {pend_q[0][6:0], pend_q[1]};
                else              exp_div  = {pend_q[0][6:0], pend_q[1]};
                pend_q.delete();
            end
        end
    endtask

    task automatic start_c();
        sda_m = 1'b1; tick(5);
        scl_m = 1'b1; tick(10);
        sda_m = 1'b0; model_start(); tick(10);
        scl_m = 1'b0; tick(5);
    endtask

    task automatic stop_c();
        sda_m = 1'b0; tick(5);
        scl_m = 1'b1; tick(10);
        sda_m = 1'b1; model_start(); tick(10);
    endtask

    task automatic send_bit(logic b);
        sda_m = b; tick(5);
        scl_m = 1'b1; tick(10);
        scl_m = 1'b0; tick(5);
    endtask

    task automatic wr_byte(logic [7:0] b, bit is_addr, bit exp_ack, string req);
        for (int i = 7; i > 0; i--) send_bit(b[i]);
        sda_m = b[0]; tick(5);
        scl_m = 1'b1; tick(10);
        model_byte(b, is_addr);
        scl_m = 1'b0; tick(5);
        sda_m = 1'b1; tick(5);
        chk(req, "ack", {15'd0, sda_oe}, {15'd0, exp_ack});
        scl_m = 1'b1; tick(10);
        scl_m = 1'b0; tick(5);
        if (exp_ack && !(is_addr && b[0])) begin
            tick(1);
            chk("R10", "release_after_ack", {15'd0, sda_oe}, 16'd0);
        end
    endtask

    task automatic rd_byte(logic [7:0] exp, string req);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; tick(5);
            chk(req, "status_bit", {15'd0, sda_line}, {15'd0, exp[i]});
            scl_m = 1'b1; tick(10);
            scl_m = 1'b0; tick(5);
        end
        sda_m = 1'b1; tick(5);
        chk("R10", "release_after_read", {15'd0, sda_oe}, 16'd0);
        scl_m = 1'b1; tick(10);
        scl_m = 1'b0; tick(5);
    endtask

    task automatic run_all();
        tick(5);
        rst_n = 1'b1;
        tick(5);
        // R1 reset state
        chk("R1", "oe", {15'd0, sda_oe}, 16'd0);
        chk("R1", "div", {1'b0, div_w}, 16'd0);
        chk("R1", "ctrl", {1'b0, ctrl_w}, 16'd0);
        cmp_en = 1'b1;

        // R2 R4 divider word
        cur = "R4";
        start_c();
        wr_byte(8'hC2, 1'b1, 1'b1, "R2");
        wr_byte(8'h12, 1'b0, 1'b1, "R4");
        wr_byte(8'h34, 1'b0, 1'b1, "R4");
        stop_c();
        chk("R4", "div_final", {1'b0, div_w}, 16'h1234);

        // R5 control word
        cur = "R5";
        start_c();
        wr_byte(8'hC2, 1'b1, 1'b1, "R2");
        wr_byte(8'h85, 1'b0, 1'b1, "R5");
        wr_byte(8'h5A, 1'b0, 1'b1, "R5");
        stop_c();
        chk("R5", "ctrl_final", {1'b0, ctrl_w}, 16'h055A);

        // R6 third byte selects again
        cur = "R6";
        start_c();
        wr_byte(8'hC2, 1'b1, 1'b1, "R2");
        wr_byte(8'h9F, 1'b0, 1'b1, "R6");
        wr_byte(8'h01, 1'b0, 1'b1, "R6");
        wr_byte(8'h7E, 1'b0, 1'b1, "R6");
        wr_byte(8'hFF, 1'b0, 1'b1, "R6");
        stop_c();
        chk("R6", "ctrl_final", {1'b0, ctrl_w}, 16'h1F01);
        chk("R6", "div_final", {1'b0, div_w}, 16'h7EFF);

        // R7 incomplete pair discarded
        cur = "R7";
        start_c();
        wr_byte(8'hC2, 1'b1, 1'b1, "R2");
        wr_byte(8'h33, 1'b0, 1'b1, "R7");
        wr_byte(8'h44, 1'b0, 1'b1, "R7");
        wr_byte(8'h55, 1'b0, 1'b1, "R7");
        stop_c();
        start_c();
        wr_byte(8'hC2, 1'b1, 1'b1, "R2");
        wr_byte(8'h81, 1'b0, 1'b1, "R7");
        wr_byte(8'h02, 1'b0, 1'b1, "R7");
        stop_c();
        chk("R7", "div_final", {1'b0, div_w}, 16'h3344);
        chk("R7", "ctrl_final", {1'b0, ctrl_w}, 16'h0102);

        // R3 address mismatch ignored until next start
        cur = "R3";
        start_c();
        wr_byte(8'hC4, 1'b1, 1'b0, "R3");
        wr_byte(8'h11, 1'b0, 1'b0, "R3");
        wr_byte(8'h22, 1'b0, 1'b0, "R3");
        chk("R3", "div_unchanged", {1'b0, div_w}, 16'h3344);
        start_c();
        wr_byte(8'hC2, 1'b1, 1'b1, "R3");
        wr_byte(8'h10, 1'b0, 1'b1, "R3");
        wr_byte(8'h20, 1'b0, 1'b1, "R3");
        stop_c();
        chk("R3", "div_after_restart", {1'b0, div_w}, 16'h1020);

        // R8 status reads
        cur = "R8";
        lock = 1'b1;
        start_c();
        wr_byte(8'hC3, 1'b1, 1'b1, "R8");
        rd_byte(8'h80, "R8");
        stop_c();
        lock = 1'b0;
        start_c();
        wr_byte(8'hC3, 1'b1, 1'b1, "R8");
        rd_byte(8'h00, "R8");
        stop_c();
        chk("R8", "div_kept", {1'b0, div_w}, 16'h1020);

        // R9 repeated start drops half pair
        cur = "R9";
        start_c();
        wr_byte(8'hC2, 1'b1, 1'b1, "R9");
        wr_byte(8'h05, 1'b0, 1'b1, "R9");
        start_c();
        wr_byte(8'hC2, 1'b1, 1'b1, "R9");
        wr_byte(8'h06, 1'b0, 1'b1, "R9");
        wr_byte(8'h07, 1'b0, 1'b1, "R9");
        stop_c();
        chk("R9", "div_final", {1'b0, div_w}, 16'h0607);
        tick(20);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog act=running exp=finished");
            end
        join_any
        cmp_en = 1'b0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule